// File: doc/BRIEF.md
# Execute Redirect and Squash Selector

This block sits at the end of the execute stage of a multi-threaded out-of-order core. Each cycle it looks at the results coming out of the execution lanes, together with one memory-ordering-violation indication and one blocked-load indication from the load/store unit. For every hardware thread it decides whether the pipeline must be squashed and fetch redirected. When a squash is needed, it forms the message that is handed to commit.

Three causes compete for each thread, in a fixed order. A branch mispredict found in a lane wins first. A memory-ordering violation comes next, and a blocked load comes last. Each cause sets its own restart address and its own rule for whether the triggering instruction is squashed along with younger work. At most one redirect per thread is accepted in a cycle, and the per-cycle choice starts afresh on every clock. When the block takes a violation or a blocked load, it acknowledges it in the same cycle so that the load/store unit can retire the condition. A cause that loses is not acknowledged, so it stays pending. Two running counters split the accepted mispredicts by their predicted direction, and a third output gives their sum.

Top module: `exec_redirect_sel`

## Requirements
- R1: While reset is asserted, and after its release until the first stimulus, every `sq_valid` bit is 0 and all three counters read 0.
- R2: For each thread, at most one squash record is produced per cycle. The record appears on the `sq_*` outputs in the cycle after the inputs that caused it, and `sq_valid` is 0 in any cycle that follows a cycle with no cause for that thread. Fields of an invalid record read 0.
- R3: The priority within a thread is: branch mispredict first, then ordering violation, then blocked load. Among mispredicting lanes of one thread, the lowest lane index wins.
- R4: A branch record carries the branch's sequence number, the branch PC in `sq_mispred_pc`, its next PC in `sq_restart_pc`, `sq_mispred`=1 and `sq_incl_self`=0.
- R5: In a branch record, `sq_taken` is 1 exactly when the next PC differs from PC + INST_BYTES, computed modulo 2^PC_W (default INST_BYTES = 4).
- R6: An ordering-violation record carries `ord_seq`, restart PC `ord_npc`, `sq_incl_self`=0, `sq_mispred`=0, `sq_taken`=0 and `sq_mispred_pc`=0. `ord_ack` is 1 in the same cycle exactly when this cause is taken.
- R7: A blocked-load record carries `lb_seq`, restart PC `lb_pc` (the load itself), `sq_incl_self`=1, `sq_mispred`=0, `sq_taken`=0 and `sq_mispred_pc`=0. `lb_ack` is 1 in the same cycle exactly when this cause is taken.
- R8: A lane whose valid bit is 0, whose squashed bit is 1, or whose mispredict bit is 0 never causes a redirect.
- R9: `cnt_taken_wrong` counts accepted branch redirects whose predicted-taken bit was 1. `cnt_nottaken_wrong` counts those whose bit was 0. `cnt_mispred_total` equals their sum. Each counter updates one cycle after the redirect.
- R10: Threads are independent: a redirect taken for one thread does not suppress or alter the choice for another thread.
- R11: A violation or blocked-load indication that loses to a higher-priority cause of the same thread is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | LANES | Lane carries an executed result |
| ex_squashed | input | LANES | Lane's instruction was already squashed |
| ex_mispred | input | LANES | Lane's branch was mispredicted |
| ex_pred_taken | input | LANES | Lane's branch had been predicted taken |
| ex_tid | input | LANES*TID_W | Thread id per lane |
| ex_seq | input | LANES*SEQ_W | Sequence number per lane |
| ex_pc | input | LANES*PC_W | PC per lane |
| ex_npc | input | LANES*PC_W | Resolved next PC per lane |
| ord_valid | input | 1 | Memory-ordering violation present |
| ord_tid | input | TID_W | Thread of the violation |
| ord_seq | input | SEQ_W | Sequence number of the violating instruction |
| ord_npc | input | PC_W | Next PC of the violating instruction |
| ord_ack | output | 1 | Violation taken this cycle |
| lb_valid | input | 1 | Unhandled blocked load present |
| lb_tid | input | TID_W | Thread of the blocked load |
| lb_seq | input | SEQ_W | Sequence number of the blocked load |
| lb_pc | input | PC_W | PC of the blocked load |
| lb_ack | output | 1 | Blocked load taken (marked handled) this cycle |
| sq_valid | output | NT | Squash record valid per thread |
| sq_seq | output | NT*SEQ_W | Squash sequence number per thread |
| sq_restart_pc | output | NT*PC_W | Restart PC per thread |
| sq_mispred_pc | output | NT*PC_W | Mispredicted branch PC per thread |
| sq_mispred | output | NT | Record comes from a branch mispredict |
| sq_taken | output | NT | Mispredicted branch resolved taken |
| sq_incl_self | output | NT | Triggering instruction is squashed too |
| cnt_taken_wrong | output | CNT_W | Mispredicts that had been predicted taken |
| cnt_nottaken_wrong | output | CNT_W | Mispredicts that had been predicted not-taken |
| cnt_mispred_total | output | CNT_W | Sum of both mispredict counters |

## Verification
Every piece of per-cycle state is registered exactly once, so a wrong decision shows up one cycle after its inputs. It can appear as a record on the wrong thread, a wrong restart address, an include-self bit of the wrong polarity, or a wrong cause flag. A wrong priority decision shows up earlier, in the same cycle, as an acknowledge that rises or stays low when it should not. A counter that was bumped on the wrong predicted direction stays wrong from then on, and it shows on the very next cycle. The sweep therefore compares every output on every cycle against a model built from the requirements.

// File: rtl/exr_pkg.sv
package exr_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BRANCH  = 2'd1,
    CAUSE_ORDER   = 2'd2,
    CAUSE_LOADBLK = 2'd3
  } cause_e;
endpackage

// File: rtl/exr_lane_pick.sv
module exr_lane_pick #(
  parameter int LANES  = 2,
  parameter int TID_W  = 1,
  parameter int SEQ_W  = 8,
  parameter int PC_W   = 16,
  parameter int THREAD = 0
) (
  input  logic [LANES-1:0]       valid,
  input  logic [LANES-1:0]       squashed,
  input  logic [LANES-1:0]       mispred,
  input  logic [LANES-1:0]       pred_taken,
  input  logic [LANES*TID_W-1:0] tid,
  input  logic [LANES*SEQ_W-1:0] seq,
  input  logic [LANES*PC_W-1:0]  pc,
  input  logic [LANES*PC_W-1:0]  npc,
  output logic                   hit,
  output logic                   hit_pred_taken,
  output logic [SEQ_W-1:0]       hit_seq,
  output logic [PC_W-1:0]        hit_pc,
  output logic [PC_W-1:0]        hit_npc
);
  logic [LANES-1:0] cand;

  for (genvar l = 0; l < LANES; l++) begin : g_cand
    assign cand[l] = valid[l] & ~squashed[l] & mispred[l] &
                     (tid[l*TID_W +: TID_W] == TID_W'(THREAD));
  end

  // descending scan: the lowest lane index is assigned last and wins
  always_comb begin
    hit            = 1'b0;
    hit_pred_taken = 1'b0;
    hit_seq        = '0;
    hit_pc         = '0;
    hit_npc        = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (cand[l]) begin
        hit            = 1'b1;
        hit_pred_taken = pred_taken[l];
        hit_seq        = seq[l*SEQ_W +: SEQ_W];
        hit_pc         = pc[l*PC_W +: PC_W];
        hit_npc        = npc[l*PC_W +: PC_W];
      end
    end
  end
endmodule

// File: rtl/exr_cause_arb.sv
module exr_cause_arb
  import exr_pkg::*;
#(
  parameter int SEQ_W      = 8,
  parameter int PC_W       = 16,
  parameter int INST_BYTES = 4
) (
  input  logic             br_hit,
  input  logic [SEQ_W-1:0] br_seq,
  input  logic [PC_W-1:0]  br_pc,
  input  logic [PC_W-1:0]  br_npc,
  input  logic             ord_hit,
  input  logic [SEQ_W-1:0] ord_seq,
  input  logic [PC_W-1:0]  ord_npc,
  input  logic             lb_hit,
  input  logic [SEQ_W-1:0] lb_seq,
  input  logic [PC_W-1:0]  lb_pc,
  output cause_e           cause,
  output logic             rec_valid,
  output logic [SEQ_W-1:0] rec_seq,
  output logic [PC_W-1:0]  rec_restart,
  output logic [PC_W-1:0]  rec_mpc,
  output logic             rec_mispred,
  output logic             rec_taken,
  output logic             rec_incl,
  output logic             ord_take,
  output logic             lb_take
);
  function automatic logic leaves_fallthrough(input logic [PC_W-1:0] pc,
                                              input logic [PC_W-1:0] npc);
    return npc != (pc + PC_W'(INST_BYTES));
  endfunction

  always_comb begin
    if (br_hit)       cause = CAUSE_BRANCH;
    else if (ord_hit) cause = CAUSE_ORDER;
    else if (lb_hit)  cause = CAUSE_LOADBLK;
    else              cause = CAUSE_NONE;
  end

  assign ord_take = (cause == CAUSE_ORDER);
  assign lb_take  = (cause == CAUSE_LOADBLK);

  always_comb begin
    rec_valid   = (cause != CAUSE_NONE);
    rec_seq     = '0;
    rec_restart = '0;
    rec_mpc     = '0;
    rec_mispred = 1'b0;
    rec_taken   = 1'b0;
    rec_incl    = 1'b0;
    unique case (cause)
      CAUSE_BRANCH: begin
        rec_seq     = br_seq;
        rec_restart = br_npc;
        rec_mpc     = br_pc;
        rec_mispred = 1'b1;
        rec_taken   = leaves_fallthrough(br_pc, br_npc);
      end
      CAUSE_ORDER: begin
        rec_seq     = ord_seq;
        rec_restart = ord_npc;
      end
      CAUSE_LOADBLK: begin
        rec_seq     = lb_seq;
        rec_restart = lb_pc;
        rec_incl    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exr_mispred_ctr.sv
module exr_mispred_ctr #(
  parameter int NT    = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    br_take,
  input  logic [NT-1:0]    br_pt,
  output logic [CNT_W-1:0] cnt_pt,
  output logic [CNT_W-1:0] cnt_pnt,
  output logic [CNT_W-1:0] cnt_all
);
  logic [NT-1:0] inc_pt, inc_pnt;
  assign inc_pt  = br_take & br_pt;
  assign inc_pnt = br_take & ~br_pt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_pt  <= '0;
      cnt_pnt <= '0;
    end else begin
      cnt_pt  <= cnt_pt  + CNT_W'($countones(inc_pt));
      cnt_pnt <= cnt_pnt + CNT_W'($countones(inc_pnt));
    end
  end

  assign cnt_all = cnt_pt + cnt_pnt;

  a_r9_pt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pt - $past(cnt_pt)) <= CNT_W'(NT));
  a_r9_pnt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pnt == '0) |=> $stable(cnt_pnt));
endmodule

// File: rtl/exec_redirect_sel.sv
module exec_redirect_sel
  import exr_pkg::*;
#(
  parameter int  NT         = 2,
  parameter int  LANES      = 2,
  parameter int  SEQ_W      = 8,
  parameter int  PC_W       = 16,
  parameter int  INST_BYTES = 4,
  parameter int  CNT_W      = 16,
  localparam int TID_W      = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       ex_valid,
  input  logic [LANES-1:0]       ex_squashed,
  input  logic [LANES-1:0]       ex_mispred,
  input  logic [LANES-1:0]       ex_pred_taken,
  input  logic [LANES*TID_W-1:0] ex_tid,
  input  logic [LANES*SEQ_W-1:0] ex_seq,
  input  logic [LANES*PC_W-1:0]  ex_pc,
  input  logic [LANES*PC_W-1:0]  ex_npc,
  input  logic                   ord_valid,
  input  logic [TID_W-1:0]       ord_tid,
  input  logic [SEQ_W-1:0]       ord_seq,
  input  logic [PC_W-1:0]        ord_npc,
  output logic                   ord_ack,
  input  logic                   lb_valid,
  input  logic [TID_W-1:0]       lb_tid,
  input  logic [SEQ_W-1:0]       lb_seq,
  input  logic [PC_W-1:0]        lb_pc,
  output logic                   lb_ack,
  output logic [NT-1:0]          sq_valid,
  output logic [NT*SEQ_W-1:0]    sq_seq,
  output logic [NT*PC_W-1:0]     sq_restart_pc,
  output logic [NT*PC_W-1:0]     sq_mispred_pc,
  output logic [NT-1:0]          sq_mispred,
  output logic [NT-1:0]          sq_taken,
  output logic [NT-1:0]          sq_incl_self,
  output logic [CNT_W-1:0]       cnt_taken_wrong,
  output logic [CNT_W-1:0]       cnt_nottaken_wrong,
  output logic [CNT_W-1:0]       cnt_mispred_total
);
  // named per-thread events, visible to the assertions
  logic [NT-1:0] br_hit, br_pt, ord_take, lb_take;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic             ord_hit_t, lb_hit_t;
    logic [SEQ_W-1:0] br_seq_t;
    logic [PC_W-1:0]  br_pc_t, br_npc_t;
    cause_e           cause_t;
    logic             rv, rmis, rtk, rinc;
    logic [SEQ_W-1:0] rseq;
    logic [PC_W-1:0]  rrst, rmpc;
    logic             q_v, q_mis, q_tk, q_inc;
    logic [SEQ_W-1:0] q_seq;
    logic [PC_W-1:0]  q_rst, q_mpc;

    assign ord_hit_t = ord_valid & (ord_tid == TID_W'(t));
    assign lb_hit_t  = lb_valid  & (lb_tid  == TID_W'(t));

    exr_lane_pick #(.LANES(LANES), .TID_W(TID_W), .SEQ_W(SEQ_W),
                    .PC_W(PC_W), .THREAD(t)) u_pick (
      .valid(ex_valid), .squashed(ex_squashed), .mispred(ex_mispred),
      .pred_taken(ex_pred_taken), .tid(ex_tid), .seq(ex_seq),
      .pc(ex_pc), .npc(ex_npc),
      .hit(br_hit[t]), .hit_pred_taken(br_pt[t]), .hit_seq(br_seq_t),
      .hit_pc(br_pc_t), .hit_npc(br_npc_t));

    exr_cause_arb #(.SEQ_W(SEQ_W), .PC_W(PC_W),
                    .INST_BYTES(INST_BYTES)) u_arb (
      .br_hit(br_hit[t]), .br_seq(br_seq_t), .br_pc(br_pc_t),
      .br_npc(br_npc_t),
      .ord_hit(ord_hit_t), .ord_seq(ord_seq), .ord_npc(ord_npc),
      .lb_hit(lb_hit_t), .lb_seq(lb_seq), .lb_pc(lb_pc),
      .cause(cause_t), .rec_valid(rv), .rec_seq(rseq),
      .rec_restart(rrst), .rec_mpc(rmpc), .rec_mispred(rmis),
      .rec_taken(rtk), .rec_incl(rinc),
      .ord_take(ord_take[t]), .lb_take(lb_take[t]));

    // one record register per thread, reloaded every cycle
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_v <= 1'b0; q_mis <= 1'b0; q_tk <= 1'b0; q_inc <= 1'b0;
        q_seq <= '0; q_rst <= '0; q_mpc <= '0;
      end else begin
        q_v <= rv; q_mis <= rmis; q_tk <= rtk; q_inc <= rinc;
        q_seq <= rseq; q_rst <= rrst; q_mpc <= rmpc;
      end
    end

    assign sq_valid[t]                    = q_v;
    assign sq_mispred[t]                  = q_mis;
    assign sq_taken[t]                    = q_tk;
    assign sq_incl_self[t]                = q_inc;
    assign sq_seq[t*SEQ_W +: SEQ_W]       = q_seq;
    assign sq_restart_pc[t*PC_W +: PC_W]  = q_rst;
    assign sq_mispred_pc[t*PC_W +: PC_W]  = q_mpc;

    a_r3_branch_wins: assert property (@(posedge clk) disable iff (!rst_n)
      br_hit[t] |-> !ord_take[t] && !lb_take[t]);
    a_r4_branch_rec: assert property (@(posedge clk) disable iff (!rst_n)
      br_hit[t] |=> q_v && q_mis && !q_inc);
    a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (q_v && q_mis && (q_rst == q_mpc + PC_W'(INST_BYTES))) |-> !q_tk);
    a_r6_order_rec: assert property (@(posedge clk) disable iff (!rst_n)
      ord_take[t] |=> q_v && !q_inc && !q_mis && (q_rst == $past(ord_npc)));
    a_r7_load_rec: assert property (@(posedge clk) disable iff (!rst_n)
      lb_take[t] |=> q_v && q_inc && !q_mis && (q_rst == $past(lb_pc)));
    a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_hit[t] && !ord_hit_t && !lb_hit_t) |=> !q_v);
  end

  assign ord_ack = |ord_take;
  assign lb_ack  = |lb_take;

  a_r11_ord_ack_src: assert property (@(posedge clk) disable iff (!rst_n)
    ord_ack |-> ord_valid);
  a_r11_lb_ack_src: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ack |-> lb_valid);

  exr_mispred_ctr #(.NT(NT), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .br_take(br_hit), .br_pt(br_pt),
    .cnt_pt(cnt_taken_wrong), .cnt_pnt(cnt_nottaken_wrong),
    .cnt_all(cnt_mispred_total));
endmodule

// File: tb/exec_redirect_sel_tb.sv
`timescale 1ns/1ps
module exec_redirect_sel_tb;
  localparam int NT = 2, LANES = 2, TID_W = 1, SEQ_W = 8, PC_W = 16;
  localparam int IB = 4, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [LANES-1:0] ex_valid, ex_squashed, ex_mispred, ex_pred_taken;
  logic [TID_W-1:0] a_tid [LANES];
  logic [SEQ_W-1:0] a_seq [LANES];
  logic [PC_W-1:0]  a_pc  [LANES], a_npc [LANES];
  logic [LANES*TID_W-1:0] ex_tid;
  logic [LANES*SEQ_W-1:0] ex_seq;
  logic [LANES*PC_W-1:0]  ex_pc, ex_npc;
  logic ord_valid, lb_valid, ord_ack, lb_ack;
  logic [TID_W-1:0] ord_tid, lb_tid;
  logic [SEQ_W-1:0] ord_seq, lb_seq;
  logic [PC_W-1:0]  ord_npc, lb_pc;
  logic [NT-1:0] sq_valid, sq_mispred, sq_taken, sq_incl_self;
  logic [NT*SEQ_W-1:0] sq_seq;
  logic [NT*PC_W-1:0]  sq_restart_pc, sq_mispred_pc;
  logic [CNT_W-1:0] cnt_taken_wrong, cnt_nottaken_wrong, cnt_mispred_total;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      ex_tid[l*TID_W +: TID_W] = a_tid[l];
      ex_seq[l*SEQ_W +: SEQ_W] = a_seq[l];
      ex_pc[l*PC_W +: PC_W]    = a_pc[l];
      ex_npc[l*PC_W +: PC_W]   = a_npc[l];
    end
  end

  exec_redirect_sel u_dut (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_squashed(ex_squashed),
    .ex_mispred(ex_mispred), .ex_pred_taken(ex_pred_taken), .ex_tid(ex_tid),
    .ex_seq(ex_seq), .ex_pc(ex_pc), .ex_npc(ex_npc),
    .ord_valid(ord_valid), .ord_tid(ord_tid), .ord_seq(ord_seq),
    .ord_npc(ord_npc), .ord_ack(ord_ack),
    .lb_valid(lb_valid), .lb_tid(lb_tid), .lb_seq(lb_seq), .lb_pc(lb_pc),
    .lb_ack(lb_ack), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .sq_restart_pc(sq_restart_pc), .sq_mispred_pc(sq_mispred_pc),
    .sq_mispred(sq_mispred), .sq_taken(sq_taken), .sq_incl_self(sq_incl_self),
    .cnt_taken_wrong(cnt_taken_wrong), .cnt_nottaken_wrong(cnt_nottaken_wrong),
    .cnt_mispred_total(cnt_mispred_total));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected state computed from the requirements
  logic e_v [NT], e_mis [NT], e_tk [NT], e_inc [NT];
  logic [SEQ_W-1:0] e_seq [NT];
  logic [PC_W-1:0]  e_rst [NT], e_mpc [NT];
  string e_tag [NT];
  logic e_oack, e_lack;
  int e_pt = 0, e_pnt = 0;

  task automatic model();
    e_oack = 1'b0; e_lack = 1'b0;
    for (int t = 0; t < NT; t++) begin
      bit found = 1'b0;
      e_v[t] = 1'b0; e_mis[t] = 1'b0; e_tk[t] = 1'b0; e_inc[t] = 1'b0;
      e_seq[t] = '0; e_rst[t] = '0; e_mpc[t] = '0; e_tag[t] = "R2 R8 R10 none";
      for (int l = 0; l < LANES; l++) begin
        if (!found && ex_valid[l] && !ex_squashed[l] && ex_mispred[l] &&
            int'(a_tid[l]) == t) begin
          found = 1'b1;
          e_v[t] = 1'b1; e_mis[t] = 1'b1; e_seq[t] = a_seq[l];
          e_rst[t] = a_npc[l]; e_mpc[t] = a_pc[l];
          e_tk[t] = (int'(a_npc[l]) != ((int'(a_pc[l]) + IB) % 65536));
          e_tag[t] = "R3 R4 R5 branch";
          if (ex_pred_taken[l]) e_pt++; else e_pnt++;
        end
      end
      if (!found && ord_valid && int'(ord_tid) == t) begin
        e_v[t] = 1'b1; e_seq[t] = ord_seq; e_rst[t] = ord_npc;
        e_oack = 1'b1; e_tag[t] = "R3 R6 order";
      end else if (!found && lb_valid && int'(lb_tid) == t) begin
        e_v[t] = 1'b1; e_seq[t] = lb_seq; e_rst[t] = lb_pc; e_inc[t] = 1'b1;
        e_lack = 1'b1; e_tag[t] = "R3 R7 load";
      end
    end
  endtask

  // inputs were set at the falling edge; acks are checked combinationally,
  // records and counters one rising edge later
  task automatic step();
    #1;
    model();
    chk("R6 R11 ord_ack", 32'(ord_ack), 32'(e_oack));
    chk("R7 R11 lb_ack", 32'(lb_ack), 32'(e_lack));
    @(posedge clk); #1;
    for (int t = 0; t < NT; t++) begin
      chk({e_tag[t], " R2 valid"}, 32'(sq_valid[t]), 32'(e_v[t]));
      chk({e_tag[t], " seq"}, 32'(sq_seq[t*SEQ_W +: SEQ_W]), 32'(e_seq[t]));
      chk({e_tag[t], " restart"}, 32'(sq_restart_pc[t*PC_W +: PC_W]), 32'(e_rst[t]));
      chk({e_tag[t], " mpc"}, 32'(sq_mispred_pc[t*PC_W +: PC_W]), 32'(e_mpc[t]));
      chk({e_tag[t], " mispred"}, 32'(sq_mispred[t]), 32'(e_mis[t]));
      chk({e_tag[t], " taken"}, 32'(sq_taken[t]), 32'(e_tk[t]));
      chk({e_tag[t], " incl"}, 32'(sq_incl_self[t]), 32'(e_inc[t]));
    end
    chk("R9 taken_wrong", 32'(cnt_taken_wrong), 32'(e_pt % 65536));
    chk("R9 nottaken_wrong", 32'(cnt_nottaken_wrong), 32'(e_pnt % 65536));
    chk("R9 total", 32'(cnt_mispred_total), 32'((e_pt + e_pnt) % 65536));
  endtask

  task automatic clear_inputs();
    ex_valid = '0; ex_squashed = '0; ex_mispred = '0; ex_pred_taken = '0;
    for (int l = 0; l < LANES; l++) begin
      a_tid[l] = '0; a_seq[l] = '0; a_pc[l] = '0; a_npc[l] = '0;
    end
    ord_valid = 1'b0; ord_tid = '0; ord_seq = '0; ord_npc = '0;
    lb_valid = 1'b0; lb_tid = '0; lb_seq = '0; lb_pc = '0;
  endtask

  task automatic one_branch(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] npc,
                            input logic squashed);
    @(negedge clk);
    clear_inputs();
    ex_valid[0] = 1'b1; ex_mispred[0] = 1'b1; ex_squashed[0] = squashed;
    a_seq[0] = 8'h5A; a_pc[0] = pc; a_npc[0] = npc;
    step();
  endtask

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    #1;
    // R1: state held in reset
    chk("R1 valid in reset", 32'(sq_valid), 32'h0);
    chk("R1 total in reset", 32'(cnt_mispred_total), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", 32'(sq_valid), 32'h0);
    chk("R1 taken_wrong after reset", 32'(cnt_taken_wrong), 32'h0);
    chk("R1 nottaken_wrong after reset", 32'(cnt_nottaken_wrong), 32'h0);

    // R5 boundaries: fall-through, wrap at the top of the address space, jump
    one_branch(16'h0100, 16'h0104, 1'b0);
    one_branch(16'hFFFC, 16'h0000, 1'b0);
    one_branch(16'hFFFC, 16'h0004, 1'b0);
    one_branch(16'h0100, 16'h0200, 1'b0);
    // R8: a squashed mispredicting lane is ignored
    one_branch(16'h0300, 16'h0400, 1'b1);

    // sweep of all lane/indication flag combinations with random payloads;
    // covers R3 priority, R10 thread independence and R11 withheld acks
    for (int c = 0; c < 4096; c++) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        logic [3:0] f;
        logic [PC_W-1:0] p;
        f = 4'((c >> (4 * l)) & 15);
        ex_valid[l]      = f[0];
        a_tid[l]         = f[1];
        ex_mispred[l]    = f[2];
        ex_squashed[l]   = f[3];
        ex_pred_taken[l] = 1'($urandom);
        a_seq[l]         = 8'($urandom);
        p                = 16'($urandom) & 16'hFFFC;
        a_pc[l]          = p;
        a_npc[l]         = ($urandom % 2 == 0) ? 16'(p + 16'(IB)) : (16'($urandom) & 16'hFFFC);
      end
      ord_valid = 1'((c >> 8) & 1);
      ord_tid   = 1'((c >> 9) & 1);
      lb_valid  = 1'((c >> 10) & 1);
      lb_tid    = 1'((c >> 11) & 1);
      ord_seq   = 8'($urandom);
      ord_npc   = 16'($urandom);
      lb_seq    = 8'($urandom);
      lb_pc     = 16'($urandom);
      step();
    end

    // R2: a quiet cycle drops every record
    @(negedge clk);
    clear_inputs();
    step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule